// File: doc/BRIEF.md
# Local History Pattern Predictor

This block predicts whether a conditional branch will be taken. It is a two-level scheme. A small table of branch entries is indexed by a few low bits of the branch address. Each entry holds a short shift register with that branch's most recent outcomes, plus a private bank of sixteen 2-bit saturating counters. The current shift-register value selects one counter in the bank, and the upper bit of that counter is the prediction. Because each history pattern trains its own counter, the block can learn short repeating sequences, such as a loop that exits every fourth pass, that a single counter per branch always gets wrong.

The fetch side presents an address on the predict port and reads the taken or not-taken answer combinationally in the same cycle. When the branch resolves, the execute side presents the same address and the real outcome on the update port for one cycle. The update trains the counter chosen by the entry's present history, then shifts the outcome into that history. Updates are expected in program order. The block keeps no speculative copy of the history.

Top module: `local_hist_predictor`

## Requirements
- R1: After reset every history register holds 0000 and every counter holds 1, so every address predicts not-taken.
- R2: The entry is chosen by address bits `[IDX_SHIFT +: IDX_W]` (bits 4:2 by default). Addresses that agree in those bits share one entry and its state. Addresses that differ there do not affect each other.
- R3: `predTaken` is the upper bit of the counter that the entry's current history selects. It follows `predPc` combinationally within the same cycle.
- R4: A counter saturates. A taken outcome at 3 leaves it at 3, and a not-taken outcome at 0 leaves it at 0. It never wraps.
- R5: An update trains only the one counter selected by the history the entry holds at update time, adding 1 for taken and subtracting 1 for not-taken. The other fifteen counters of that entry are unchanged.
- R6: On each update the history shifts one place toward the MSB and the outcome (1 = taken) enters at bit 0. The oldest outcome drops off the top.
- R7: When `updValid` is low, no history and no counter changes, whatever `updPc` and `updTaken` carry.
- R8: An update takes effect at the rising clock edge where `updValid` is high. A prediction read in that same cycle sees the state from before the update.
- R9: A branch whose outcomes repeat with period four (taken, taken, taken, not-taken) is predicted without a miss once it has been trained for several periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| predPc | input | PC_W | Branch address to predict |
| predTaken | output | 1 | Prediction for `predPc`, 1 = taken |
| updValid | input | 1 | Update strobe for one resolved branch |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench drives a counter to both ends of its range and then pushes past each end. A counter that wraps would flip the prediction right after it had been saturated. It checks that a pattern counter stays untrained after its neighbour was trained. A design that trained the wrong counter, or used the history from after the shift, would predict early. Two addresses that share index bits must give the same answer, and an address in another entry must keep its reset answer. A loop-exit pattern must be predicted perfectly after training, which fails if the history shifts the wrong way or drops the wrong bit. The bench also reads a prediction in the same cycle as an update, which exposes a write-through path. It holds `updValid` low while other update inputs are active, which exposes an update that ignores the strobe.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

  // Outcomes remembered per branch entry
  localparam int HIST_W = 4;
  // Width of each saturating counter
  localparam int CTR_W = 2;
  // Derived counter limits and reset level (weakly not-taken)
  localparam logic [CTR_W-1:0] CTR_MAX  = CTR_W'((1 << CTR_W) - 1);
  localparam logic [CTR_W-1:0] CTR_MIN  = '0;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W - 1)) - 1);

  // Strobes handed from control to datapath for one update
  typedef struct packed {
    logic              wrEn;
    logic [CTR_W-1:0]  ctrNext;
    logic [HIST_W-1:0] histNext;
  } lhp_strb_t;

endpackage

// File: rtl/lhp_ctrl.sv
module lhp_ctrl
  import lhp_pkg::*;
(
  input  logic              updValid,
  input  logic              updTaken,
  input  logic [HIST_W-1:0] updHist,
  input  logic [CTR_W-1:0]  updCtr,
  output lhp_strb_t         strb
);

  logic [CTR_W-1:0] ctrUp;
  logic [CTR_W-1:0] ctrDown;

  // Saturating step in each direction
  always_comb begin
    ctrUp   = (updCtr == CTR_MAX) ? CTR_MAX : updCtr + CTR_W'(1);
    ctrDown = (updCtr == CTR_MIN) ? CTR_MIN : updCtr - CTR_W'(1);
  end

  always_comb begin
    strb.wrEn     = updValid;
    strb.ctrNext  = updTaken ? ctrUp : ctrDown;
    strb.histNext = {updHist[HIST_W-2:0], updTaken};
  end

endmodule

// File: rtl/lhp_datapath.sv
module lhp_datapath
  import lhp_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int IDX_W     = 3,
  parameter int IDX_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   predPc,
  input  logic [PC_W-1:0]   updPc,
  input  lhp_strb_t         strb,
  output logic              predTaken,
  output logic [HIST_W-1:0] updHist,
  output logic [CTR_W-1:0]  updCtr
);

  localparam int ENTRIES  = 1 << IDX_W;
  localparam int PATTERNS = 1 << HIST_W;

  logic [IDX_W-1:0]  predIdx;
  logic [IDX_W-1:0]  updIdx;
  logic [HIST_W-1:0] predHist;
  logic [CTR_W-1:0]  predCtr;

  logic [HIST_W-1:0] histQ [ENTRIES];
  logic [CTR_W-1:0]  ctrQ  [ENTRIES][PATTERNS];

  assign predIdx = predPc[IDX_SHIFT +: IDX_W];
  assign updIdx  = updPc[IDX_SHIFT +: IDX_W];

  for (genvar gE = 0; gE < ENTRIES; gE++) begin : gEntry
    logic              hitEntry;
    logic [HIST_W-1:0] histR;

    assign hitEntry = strb.wrEn && (updIdx == IDX_W'(gE));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         histR <= '0;
      else if (hitEntry) histR <= strb.histNext;
    end
    assign histQ[gE] = histR;

    for (genvar gP = 0; gP < PATTERNS; gP++) begin : gPat
      logic [CTR_W-1:0] ctrR;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                      ctrR <= CTR_INIT;
        else if (hitEntry && (updHist == HIST_W'(gP))) ctrR <= strb.ctrNext;
      end
      assign ctrQ[gE][gP] = ctrR;
    end
  end

  // Predict read port
  always_comb begin
    predHist  = histQ[predIdx];
    predCtr   = ctrQ[predIdx][predHist];
    predTaken = predCtr[CTR_W-1];
  end

  // Update read port: state before the write
  always_comb begin
    updHist = histQ[updIdx];
    updCtr  = ctrQ[updIdx][updHist];
  end

endmodule

// File: rtl/local_hist_predictor.sv
module local_hist_predictor
  import lhp_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int IDX_W     = 3,
  parameter int IDX_SHIFT = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);

  lhp_strb_t         strb;
  logic [HIST_W-1:0] updHist;
  logic [CTR_W-1:0]  updCtr;

  lhp_ctrl u_ctrl (
    .updValid (updValid),
    .updTaken (updTaken),
    .updHist  (updHist),
    .updCtr   (updCtr),
    .strb     (strb)
  );

  lhp_datapath #(
    .PC_W      (PC_W),
    .IDX_W     (IDX_W),
    .IDX_SHIFT (IDX_SHIFT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .predPc    (predPc),
    .updPc     (updPc),
    .strb      (strb),
    .predTaken (predTaken),
    .updHist   (updHist),
    .updCtr    (updCtr)
  );

endmodule

// File: rtl/lhp_checker.sv
module lhp_checker
  import lhp_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int IDX_W     = 3,
  parameter int IDX_SHIFT = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              updValid,
  input logic              updTaken,
  input logic [PC_W-1:0]   updPc,
  input logic [HIST_W-1:0] updHist,
  input logic [CTR_W-1:0]  updCtr,
  input lhp_strb_t         strb
);

  logic [IDX_W-1:0] updIdx;
  assign updIdx = updPc[IDX_SHIFT +: IDX_W];

  // R6: history seen one cycle after an update to the same entry
  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(updValid) && (updIdx == $past(updIdx)))
      |-> (updHist == {$past(updHist[HIST_W-2:0]), $past(updTaken)}));

  // R7: without a strobe the entry keeps its history
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(updValid) && (updIdx == $past(updIdx)))
      |-> (updHist == $past(updHist)));

  // R4: top of range holds on taken
  assert_sat_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updTaken && (updCtr == CTR_MAX)) |-> (strb.ctrNext == CTR_MAX));

  // R4: bottom of range holds on not-taken
  assert_sat_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updTaken && (updCtr == CTR_MIN)) |-> (strb.ctrNext == CTR_MIN));

endmodule

bind local_hist_predictor lhp_checker #(
  .PC_W      (PC_W),
  .IDX_W     (IDX_W),
  .IDX_SHIFT (IDX_SHIFT)
) u_lhpChk (
  .clk      (clk),
  .rstN     (rstN),
  .updValid (updValid),
  .updTaken (updTaken),
  .updPc    (updPc),
  .updHist  (updHist),
  .updCtr   (updCtr),
  .strb     (strb)
);

// File: tb/local_hist_predictor_bench.sv
`timescale 1ns/1ps
module local_hist_predictor_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] predPc = '0;
  logic        predTaken;
  logic        updValid = 1'b0;
  logic [15:0] updPc = '0;
  logic        updTaken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  local_hist_predictor u_local_hist_predictor (
    .clk       (clk),
    .rstN      (rstN),
    .predPc    (predPc),
    .predTaken (predTaken),
    .updValid  (updValid),
    .updPc     (updPc),
    .updTaken  (updTaken)
  );

  // Vector: {isCheck, reqNum[3:0], pc[15:0], bit}; bit = outcome or expected prediction
  localparam int NV = 24;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 4'd1, 16'h0004, 1'b0},  // R1 reset state
    {1'b1, 4'd1, 16'h000C, 1'b0},  // R1
    {1'b0, 4'd6, 16'h0004, 1'b1},  // hist 0001, ctr0 -> 2
    {1'b1, 4'd5, 16'h0004, 1'b0},  // R5 ctr1 untouched
    {1'b0, 4'd6, 16'h0004, 1'b1},
    {1'b1, 4'd6, 16'h0004, 1'b0},  // R6 hist 0011
    {1'b0, 4'd6, 16'h0004, 1'b1},
    {1'b1, 4'd6, 16'h0004, 1'b0},  // R6 hist 0111
    {1'b0, 4'd6, 16'h0004, 1'b1},
    {1'b1, 4'd6, 16'h0004, 1'b0},  // R6 hist 1111, ctr15 = 1
    {1'b0, 4'd3, 16'h0004, 1'b1},
    {1'b1, 4'd3, 16'h0004, 1'b1},  // R3 ctr15 = 2
    {1'b0, 4'd4, 16'h0004, 1'b1},
    {1'b1, 4'd4, 16'h0004, 1'b1},  // R4 ctr15 = 3
    {1'b0, 4'd4, 16'h0004, 1'b1},
    {1'b1, 4'd4, 16'h0004, 1'b1},  // R4 stays 3
    {1'b1, 4'd2, 16'h0024, 1'b1},  // R2 alias shares entry 1
    {1'b1, 4'd2, 16'h0008, 1'b0},  // R2 entry 2 untouched
    {1'b0, 4'd6, 16'h0004, 1'b0},  // hist 1110
    {1'b1, 4'd6, 16'h0004, 1'b0},  // R6 ctr14 = 1
    {1'b1, 4'd2, 16'h0024, 1'b0},  // R2 alias follows
    {1'b0, 4'd4, 16'h0008, 1'b0},  // ctr0 1 -> 0, hist 0000
    {1'b0, 4'd4, 16'h0008, 1'b0},  // ctr0 stays 0
    {1'b1, 4'd4, 16'h0008, 1'b0}   // R4 no wrap at bottom
  };

  task automatic doUpdate(input logic [15:0] pc, input logic t);
    @(negedge clk);
    updValid = 1'b1; updPc = pc; updTaken = t;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic checkNow(input logic exp, input string tag);
    checks++;
    if (predTaken !== exp) begin
      errors++;
      $display("FAIL %s pc=%h actual=%0b expected=%0b", tag, predPc, predTaken, exp);
    end
  endtask

  task automatic checkPred(input logic [15:0] pc, input logic exp, input string tag);
    @(negedge clk);
    predPc = pc;
    #1;
    checkNow(exp, tag);
  endtask

  function automatic logic loopOutcome(input int k);
    return (k % 4) != 3;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21])
        checkPred(VEC[i][16:1], VEC[i][0], $sformatf("R%0d vec%0d", VEC[i][20:17], i));
      else
        doUpdate(VEC[i][16:1], VEC[i][0]);
    end

    // R9: loop pattern T,T,T,N on entry 3
    for (int k = 0; k < 42; k++) begin
      if (k >= 32 && k < 40) checkPred(16'h000C, loopOutcome(k), "R9 loop");
      doUpdate(16'h000C, loopOutcome(k));
    end

    // R8: same-cycle read sees old state (hist 1011 -> 1)
    @(negedge clk);
    predPc = 16'h000C;
    updValid = 1'b1; updPc = 16'h000C; updTaken = 1'b1;
    #1;
    checkNow(1'b1, "R8 before edge");
    @(negedge clk);
    updValid = 1'b0;
    #1;
    checkNow(1'b0, "R8 after edge");

    // R7: strobe low, other inputs active
    @(negedge clk);
    updPc = 16'h000C; updTaken = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    checkNow(1'b0, "R7 idle hold");

    // Valid not-taken: hist 1110 predicts taken
    doUpdate(16'h000C, 1'b0);
    checkPred(16'h000C, 1'b1, "R9 wrap to start");

    // R1: reset in the middle of a run
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    checkPred(16'h000C, 1'b0, "R1 after reset");
    checkPred(16'h0004, 1'b0, "R1 after reset");

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule